// File: doc/BRIEF.md
# Sticky Interrupt Status and Mask Unit

This block collects event pulses from the FIFO and line logic of a serial controller and presents them to software. Each event pulse sets its own bit in a sticky status register. The bit then stays set until software clears it by writing 1 to it. A read-only view beside the sticky register shows the current indicator levels, with no latching.

The enable mask cannot be written directly. Software sets mask bits through a write-only enable strobe register and clears them through a write-only disable strobe register. The mask itself can be read back. One registered interrupt line is raised whenever a latched status bit has its mask bit enabled.

Access uses a plain register bus: a word address, a write enable, write data and combinational read data. All state changes on the rising clock edge. Reset is synchronous and active low.

Top module: `irq_status_unit`

## Requirements
- R1: Each 1 on `evt_i[i]` (bits 12..0) sets sticky status bit i at the next clock edge. The bit then stays 1 until software clears it. Sticky status reads at address 0, in bits 12..0.
- R2: Writing to address 0 clears every status bit whose write-data bit is 1. Status bits written with 0 keep their value.
- R3: If an event and a clear write reach the same status bit in the same cycle, the bit is 1 afterwards.
- R4: Writing 1s to address 2 sets those mask bits to 1 (enabled). Writing 1s to address 3 clears those mask bits to 0 (masked). Zero bits in either write leave the mask bit alone. The mask reads at address 1, in bits 12..0.
- R5: Writes to any address other than 2 and 3 leave the mask unchanged.
- R6: `irq_o` is registered. It is 1 exactly one clock after the cycle in which (status AND mask) is non-zero.
- R7: Status bits latch events whether or not their mask bit is enabled. Masking only affects `irq_o`.
- R8: Address 4 reads the live indicators from `live_i`, in bit positions 14..10 and 4..0. All other bit positions read 0. The value follows `live_i` in the same cycle. Writes to address 4 change nothing.
- R9: After reset, the status, the mask and `irq_o` are all 0.
- R10: Addresses 2 and 3, and any address above 4, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 13 | Event pulses, one per status bit |
| live_i | input | 15 | Live indicator levels |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to produce is the race between an event and software's clear of the same bit. It only exists when the event pulse and the write-one-to-clear land on the same clock edge. A dedicated task drives the event input and the clear write on the same falling edge to create it. The task then reads the bit back, and also confirms that a neighbouring bit cleared in the same write does go to 0.

A second hard case is the latency of `irq_o` after a mask change made through the strobe registers. The bench samples the interrupt one edge after the mask update and checks it has not yet moved. It samples again one edge later and checks the new value.

// File: rtl/irq_agg_pkg.sv
// Package: shared address map and bus widths for the sticky interrupt unit.
// Assumes word addressing with one register per address.
package irq_agg_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_STS  = 4'd0,
        REG_MASK = 4'd1,
        REG_EN   = 4'd2,
        REG_DIS  = 4'd3,
        REG_LIVE = 4'd4
    } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
// Module: decodes bus writes into per-bit strobe vectors and muxes read data.
// Assumes one access per cycle and reads with no side effects.
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EVT_W  = 13,
    parameter int LIVE_W = 15,
    parameter logic [LIVE_W-1:0] LIVE_VIS = 15'b111110000011111
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [EVT_W-1:0]  sts_q,
    input  logic [EVT_W-1:0]  mask_q,
    input  logic [LIVE_W-1:0] live_i,
    output logic [EVT_W-1:0]  clr_v,
    output logic [EVT_W-1:0]  en_v,
    output logic [EVT_W-1:0]  dis_v,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [EVT_W-1:0] wbits;
    logic             unused_hi;

    assign wbits     = bus_wdata[EVT_W-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:EVT_W];

    // Purpose: turn a bus write into clear, enable or disable bit vectors.
    always_comb begin
        clr_v = '0;
        en_v  = '0;
        dis_v = '0;
        if (bus_we) begin
            unique case (bus_addr)
                REG_STS: clr_v = wbits;
                REG_EN:  en_v  = wbits;
                REG_DIS: dis_v = wbits;
                default: ;
            endcase
        end
    end

    // Purpose: select read data; write-only and unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_STS:  bus_rdata[EVT_W-1:0]  = sts_q;
            REG_MASK: bus_rdata[EVT_W-1:0]  = mask_q;
            REG_LIVE: bus_rdata[LIVE_W-1:0] = live_i & LIVE_VIS;
            default:  ;
        endcase
    end

    // R10: write-only strobe addresses always read back as zero.
    always_comb begin
        if (bus_addr == REG_EN || bus_addr == REG_DIS)
            a_r10_wo_reads_zero: assert (bus_rdata == '0);
    end

    // R8: live view never shows the unexposed bit positions.
    always_comb begin
        if (bus_addr == REG_LIVE)
            a_r8_live_hidden_zero: assert ((bus_rdata[LIVE_W-1:0] & ~LIVE_VIS) == '0);
    end
endmodule

// File: rtl/irq_sticky_reg.sv
// Module: sticky status bits, set by events and cleared by writing 1.
// Assumes a set and a clear on the same bit in one cycle resolve to set.
module irq_sticky_reg #(
    parameter int EVT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [EVT_W-1:0] clr_v,
    output logic [EVT_W-1:0] sts_q
);
    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        // Purpose: hold one status bit; an event overrides a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        sts_q[i] <= 1'b0;
            else if (evt_i[i]) sts_q[i] <= 1'b1;
            else if (clr_v[i]) sts_q[i] <= 1'b0;
        end
    end

    // R1: every pulsed event is latched at the next edge.
    a_r1_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

    // R2: a cleared bit with no event drops to 0.
    a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_v & ~evt_i) != '0) |=> ((sts_q & $past(clr_v & ~evt_i)) == '0));

    // R1: with no event and no clear, the status holds its value.
    a_r1_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0 && clr_v == '0) |=> $stable(sts_q));
endmodule

// File: rtl/irq_mask_reg.sv
// Module: interrupt enable mask, changed only by set and clear strobe vectors.
// Assumes a bit strobed by both vectors in one cycle keeps its old value.
module irq_mask_reg #(
    parameter int EVT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] en_v,
    input  logic [EVT_W-1:0] dis_v,
    output logic [EVT_W-1:0] mask_q
);
    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        // Purpose: set or clear one mask bit; a conflicting pair keeps it.
        always_ff @(posedge clk) begin
            if (!rst_n)                     mask_q[i] <= 1'b0;
            else if (en_v[i] && !dis_v[i])  mask_q[i] <= 1'b1;
            else if (dis_v[i] && !en_v[i])  mask_q[i] <= 1'b0;
        end
    end

    // R5: without strobes the mask does not move.
    a_r5_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_v == '0 && dis_v == '0) |=> $stable(mask_q));

    // R4: enabled bits read 1 after an enable strobe.
    a_r4_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_v & ~dis_v) != '0) |=> ((mask_q & $past(en_v & ~dis_v)) == $past(en_v & ~dis_v)));

    // R4: disabled bits read 0 after a disable strobe.
    a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((dis_v & ~en_v) != '0) |=> ((mask_q & $past(dis_v & ~en_v)) == '0));
endmodule

// File: rtl/irq_out_stage.sv
// Module: registers the OR of masked status bits into the interrupt line.
// Assumes status and mask arrive as registered values.
module irq_out_stage #(
    parameter int EVT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] sts_q,
    input  logic [EVT_W-1:0] mask_q,
    output logic             irq_o
);
    // Purpose: raise the interrupt one edge after any enabled status bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(sts_q & mask_q);
    end
endmodule

// File: rtl/irq_status_unit.sv
// Module: top of the sticky interrupt status and mask unit.
// Assumes event pulses are synchronous to clk; the read path is combinational.
module irq_status_unit
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EVT_W  = 13,
    parameter int LIVE_W = 15,
    parameter logic [LIVE_W-1:0] LIVE_VIS = 15'b111110000011111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [LIVE_W-1:0] live_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [EVT_W-1:0] sts_q, mask_q, clr_v, en_v, dis_v;

    irq_reg_decode #(
        .DATA_W(DATA_W), .EVT_W(EVT_W), .LIVE_W(LIVE_W), .LIVE_VIS(LIVE_VIS)
    ) u_dec (
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .sts_q(sts_q), .mask_q(mask_q), .live_i(live_i),
        .clr_v(clr_v), .en_v(en_v), .dis_v(dis_v), .bus_rdata(bus_rdata)
    );

    irq_sticky_reg #(.EVT_W(EVT_W)) u_sts (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_v(clr_v), .sts_q(sts_q)
    );

    irq_mask_reg #(.EVT_W(EVT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .en_v(en_v), .dis_v(dis_v), .mask_q(mask_q)
    );

    irq_out_stage #(.EVT_W(EVT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .sts_q(sts_q), .mask_q(mask_q), .irq_o(irq_o)
    );

    // R6: the interrupt follows enabled status with one cycle of latency.
    a_r6_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(sts_q & mask_q))));

    // R3: an event on a bit being cleared leaves it set.
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & clr_v) != '0) |=> ((sts_q & $past(evt_i & clr_v)) == $past(evt_i & clr_v)));

    // R5: writes to status or live addresses leave the mask unchanged.
    a_r5_other_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == REG_STS || bus_addr == REG_LIVE)) |=> $stable(mask_q));
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt_i = '0;
    logic [14:0] live_i = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int          n_chk = 0;
    int          n_err = 0;

    irq_status_unit dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .live_i(live_i),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [12:0] v);
        @(negedge clk);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); check("R9 status", d, 32'h0);
        rd(4'd1, d); check("R9 mask", d, 32'h0);
        check("R9 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_latch_masked();
        logic [31:0] d;
        pulse(13'h0005);
        rd(4'd0, d); check("R1 latch", d, 32'h5);
        @(negedge clk);
        check("R7 masked irq", {31'b0, irq_o}, 32'h0);
        repeat (3) @(negedge clk);
        rd(4'd0, d); check("R1 sticky hold", d, 32'h5);
        pulse(13'h1000);
        rd(4'd0, d); check("R7 high bit latched", d, 32'h1005);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(4'd0, 32'h1001);
        rd(4'd0, d); check("R2 clear ones", d, 32'h4);
        wr(4'd0, 32'h0);
        rd(4'd0, d); check("R2 zero keeps", d, 32'h4);
    endtask

    task automatic t_mask_irq();
        logic [31:0] d;
        wr(4'd2, 32'h0000_0006);
        rd(4'd1, d); check("R4 enable", d, 32'h6);
        check("R6 irq not yet", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R6 irq raised", {31'b0, irq_o}, 32'h1);
        wr(4'd0, 32'h4);
        check("R6 irq still high", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R6 irq drops", {31'b0, irq_o}, 32'h0);
        wr(4'd3, 32'h0000_0004);
        rd(4'd1, d); check("R4 disable", d, 32'h2);
        wr(4'd0, 32'h1FFF);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd1, d); check("R5 mask unchanged", d, 32'h2);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        evt_i = 13'h0002; bus_addr = 4'd0; bus_wdata = 32'h3; bus_we = 1'b1;
        @(negedge clk);
        evt_i = '0; bus_we = 1'b0; bus_wdata = '0;
        rd(4'd0, d); check("R3 set wins", d, 32'h2);
        @(negedge clk);
        check("R6 irq for bit1", {31'b0, irq_o}, 32'h1);
    endtask

    task automatic t_live();
        logic [31:0] d;
        live_i = 15'h7FFF;
        rd(4'd4, d); check("R8 live visible bits", d, 32'h7C1F);
        live_i = 15'h0421;
        rd(4'd4, d); check("R8 live follows", d, 32'h0401);
        wr(4'd4, 32'h0);
        rd(4'd4, d); check("R8 write ignored", d, 32'h0401);
        live_i = '0;
        rd(4'd4, d); check("R8 not latched", d, 32'h0);
    endtask

    task automatic t_readzero();
        logic [31:0] d;
        rd(4'd2, d); check("R10 enable reads 0", d, 32'h0);
        rd(4'd3, d); check("R10 disable reads 0", d, 32'h0);
        rd(4'd9, d); check("R10 unmapped reads 0", d, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_masked();
        t_w1c();
        t_mask_irq();
        t_set_wins();
        t_live();
        t_readzero();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule